// File: doc/BRIEF.md
# Smart-Card Speed Negotiation Tracker

This block listens passively to the byte stream of a smart-card line. A character receiver upstream delivers each byte with a one-cycle valid strobe. From card reset onward the tracker follows the answer to reset. That answer is the initial character, a format byte, chained groups of interface bytes, historical bytes and an optional check byte. The tracker then follows the protocol parameter selection request from the terminal and the card's reply. It skips optional fields using presence bits that it latches from the stream, so it needs no length table.

When the card accepts a speed enhancement, the tracker latches the two multiplier bits from the reply's first parameter byte. After the reply's check byte it issues a single-cycle trigger, which a sniffer uses to switch its bit clock divider. Any byte that breaks the expected structure sends the tracker to a terminal state. It stays there, doing nothing, until the card reset input is asserted again.

Top module: `card_speed_tracker`

## Requirements
- R1: While `cardRstN` is low, `speedTrigger`, `speedMult` and `trackDone` are 0, and the tracker restarts from its initial state whatever happened before.
- R2: If the first byte after reset differs from 8'h3B, `trackDone` goes high, no trigger fires and `speedMult` stays 0.
- R3: In the format byte, the low nibble gives the number of historical bytes. The high nibble flags the interface bytes, one bit each: bit 4 for A, bit 5 for B, bit 6 for C and bit 7 for D. Flagged bytes are consumed in the order A, B, C, D, and absent ones are skipped.
- R4: A D interface byte reloads the presence flags from its own bits 7:4, and a new group of interface bytes follows. If the low nibble of any D byte is nonzero, one check byte is consumed after the historical bytes.
- R5: After the interface bytes, exactly as many historical bytes are consumed as the format byte's low nibble gives.
- R6: After the answer to reset, the next byte must be 8'hFF to start a request. Any other value ends tracking.
- R7: In the request's first parameter byte, bits 4, 5 and 6 flag the presence of parameter bytes 1, 2 and 3. After those bytes, one request check byte is consumed whatever its value.
- R8: The card's reply must begin with 8'hFF. Any other value ends tracking without a trigger.
- R9: If bit 4 of the reply's first parameter byte is 0, tracking ends without a trigger. Otherwise bits 6:4 of that byte are latched as the reply's presence flags.
- R10: Bits 7:2 of the reply's parameter byte 1 must equal 6'b100101, or tracking ends without a trigger. On a match, bits 1:0 are latched onto `speedMult`.
- R11: When the reply check byte arrives, `speedTrigger` is high for exactly one cycle and `trackDone` rises with it. Later bytes cause no further trigger and leave `speedMult` unchanged until reset.
- R12: Skipping an absent field takes one cycle and consumes no byte. A byte whose strobe arrives during a skip cycle is held and consumed by the next state that waits for a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cardRstN | input | 1 | Active-low card reset; holds the tracker in its initial state |
| byteValid | input | 1 | One-cycle strobe marking a received byte |
| byteData | input | 8 | Received byte |
| speedTrigger | output | 1 | Single-cycle pulse when the speed enhancement is confirmed |
| speedMult | output | 2 | Latched multiplier code from the reply |
| trackDone | output | 1 | High once tracking has finished or been abandoned |

## Verification
Random exchanges are drawn with varying numbers of chained interface groups, historical bytes and check-byte flags. This separates correct counting and skipping of optional fields from an off-by-one or swapped presence bit, because one misplaced byte misaligns everything after it. Occasionally corrupted bytes (a wrong initial character, a missing 8'hFF, a cleared indicator bit, a mismatched multiplier tag) show that each exit to the terminal state fires on exactly its own byte. A directed case delivers a byte in the cycle right after the format byte, while absent fields are still being skipped, and tells a held byte apart from a dropped one. Resets applied after a completed exchange and in the middle of an exchange show that the tracker restarts cleanly.

// File: rtl/card_speed_pkg.sv
package card_speed_pkg;

  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int SEL_W  = 3;
  localparam int MULT_W = 2;
  localparam int TAG_W  = BYTE_W - MULT_W;

  // Presence bit positions inside the stored upper nibble
  localparam int IDX_A = 0;
  localparam int IDX_B = 1;
  localparam int IDX_C = 2;
  localparam int IDX_D = 3;

  typedef enum logic [4:0] {
    ST_INIT,
    ST_FMT,
    ST_IA,
    ST_IB,
    ST_IC,
    ST_ID,
    ST_HIST,
    ST_CHK,
    ST_RQ_WAIT,
    ST_RQ_P0,
    ST_RQ_P1,
    ST_RQ_P2,
    ST_RQ_P3,
    ST_RQ_CHK,
    ST_RS_WAIT,
    ST_RS_P0,
    ST_RS_P1,
    ST_RS_P2,
    ST_RS_P3,
    ST_RS_CHK,
    ST_DONE
  } trackState_t;

  typedef struct packed {
    logic take;      // current byte consumed this cycle
    logic loadFmt;   // format byte: presence + history count
    logic loadInd;   // D interface byte: presence + check flag
    logic decHist;   // one historical byte consumed
    logic loadSel;   // parameter presence bits from first PPS byte
    logic loadMult;  // multiplier bits
    logic fire;      // speed enhancement confirmed
  } ctlStrobe_t;

endpackage

// File: rtl/card_speed_dpath.sv
module card_speed_dpath
  import card_speed_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  input  ctlStrobe_t        strb,
  output logic              effValid,
  output logic [BYTE_W-1:0] effData,
  output logic [NIB_W-1:0]  presY,
  output logic [NIB_W-1:0]  histCnt,
  output logic              chkFlag,
  output logic [SEL_W-1:0]  ppsSel,
  output logic [MULT_W-1:0] speedMult,
  output logic              speedTrigger
);

  logic              pendValid;
  logic [BYTE_W-1:0] pendData;

  // One-entry hold for a byte that lands in a skip cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendData  <= '0;
    end else if (pendValid) begin
      if (strb.take) begin
        pendValid <= byteValid;
        pendData  <= byteData;
      end
    end else if (byteValid && !strb.take) begin
      pendValid <= 1'b1;
      pendData  <= byteData;
    end
  end

  assign effValid = pendValid | byteValid;
  assign effData  = pendValid ? pendData : byteData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presY   <= '0;
      histCnt <= '0;
      chkFlag <= 1'b0;
    end else begin
      if (strb.loadFmt) begin
        presY   <= effData[BYTE_W-1:NIB_W];
        histCnt <= effData[NIB_W-1:0];
      end
      if (strb.loadInd) begin
        presY <= effData[BYTE_W-1:NIB_W];
        if (|effData[NIB_W-1:0]) chkFlag <= 1'b1;
      end
      if (strb.decHist) histCnt <= histCnt - NIB_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ppsSel       <= '0;
      speedMult    <= '0;
      speedTrigger <= 1'b0;
    end else begin
      if (strb.loadSel)  ppsSel    <= effData[NIB_W+SEL_W-1:NIB_W];
      if (strb.loadMult) speedMult <= effData[MULT_W-1:0];
      speedTrigger <= strb.fire;
    end
  end

  AST_HIST_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.decHist |-> histCnt != '0); // R5
  AST_TRIG_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    speedTrigger |=> !speedTrigger); // R11

endmodule

// File: rtl/card_speed_ctrl.sv
module card_speed_ctrl
  import card_speed_pkg::*;
#(
  parameter logic [BYTE_W-1:0] INIT_CHAR = 8'h3B,
  parameter logic [BYTE_W-1:0] PPS_START = 8'hFF,
  parameter logic [TAG_W-1:0]  MULT_TAG  = 6'b100101
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              effValid,
  input  logic [BYTE_W-1:0] effData,
  input  logic [NIB_W-1:0]  presY,
  input  logic [NIB_W-1:0]  histCnt,
  input  logic              chkFlag,
  input  logic [SEL_W-1:0]  ppsSel,
  output ctlStrobe_t        strb,
  output logic              trackDone
);

  trackState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_INIT;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_INIT: if (effValid) begin
        strb.take = 1'b1;
        stateNext = (effData == INIT_CHAR) ? ST_FMT : ST_DONE;
      end
      ST_FMT: if (effValid) begin
        strb.take    = 1'b1;
        strb.loadFmt = 1'b1;
        stateNext    = ST_IA;
      end
      ST_IA: if (!presY[IDX_A]) stateNext = ST_IB;
        else if (effValid) begin strb.take = 1'b1; stateNext = ST_IB; end
      ST_IB: if (!presY[IDX_B]) stateNext = ST_IC;
        else if (effValid) begin strb.take = 1'b1; stateNext = ST_IC; end
      ST_IC: if (!presY[IDX_C]) stateNext = ST_ID;
        else if (effValid) begin strb.take = 1'b1; stateNext = ST_ID; end
      ST_ID: if (!presY[IDX_D]) stateNext = ST_HIST;
        else if (effValid) begin
          strb.take    = 1'b1;
          strb.loadInd = 1'b1;
          stateNext    = ST_IA;
        end
      ST_HIST: if (histCnt == '0) stateNext = ST_CHK;
        else if (effValid) begin strb.take = 1'b1; strb.decHist = 1'b1; end
      ST_CHK: if (!chkFlag) stateNext = ST_RQ_WAIT;
        else if (effValid) begin strb.take = 1'b1; stateNext = ST_RQ_WAIT; end
      ST_RQ_WAIT: if (effValid) begin
        strb.take = 1'b1;
        stateNext = (effData == PPS_START) ? ST_RQ_P0 : ST_DONE;
      end
      ST_RQ_P0: if (effValid) begin
        strb.take    = 1'b1;
        strb.loadSel = 1'b1;
        stateNext    = ST_RQ_P1;
      end
      ST_RQ_P1: if (!ppsSel[0]) stateNext = ST_RQ_P2;
        else if (effValid) begin strb.take = 1'b1; stateNext = ST_RQ_P2; end
      ST_RQ_P2: if (!ppsSel[1]) stateNext = ST_RQ_P3;
        else if (effValid) begin strb.take = 1'b1; stateNext = ST_RQ_P3; end
      ST_RQ_P3: if (!ppsSel[2]) stateNext = ST_RQ_CHK;
        else if (effValid) begin strb.take = 1'b1; stateNext = ST_RQ_CHK; end
      ST_RQ_CHK: if (effValid) begin
        strb.take = 1'b1;
        stateNext = ST_RS_WAIT;
      end
      ST_RS_WAIT: if (effValid) begin
        strb.take = 1'b1;
        stateNext = (effData == PPS_START) ? ST_RS_P0 : ST_DONE;
      end
      ST_RS_P0: if (effValid) begin
        strb.take = 1'b1;
        if (!effData[NIB_W]) stateNext = ST_DONE;
        else begin
          strb.loadSel = 1'b1;
          stateNext    = ST_RS_P1;
        end
      end
      ST_RS_P1: if (effValid) begin
        strb.take = 1'b1;
        if (effData[BYTE_W-1:MULT_W] != MULT_TAG) stateNext = ST_DONE;
        else begin
          strb.loadMult = 1'b1;
          stateNext     = ST_RS_P2;
        end
      end
      ST_RS_P2: if (!ppsSel[1]) stateNext = ST_RS_P3;
        else if (effValid) begin strb.take = 1'b1; stateNext = ST_RS_P3; end
      ST_RS_P3: if (!ppsSel[2]) stateNext = ST_RS_CHK;
        else if (effValid) begin strb.take = 1'b1; stateNext = ST_RS_CHK; end
      ST_RS_CHK: if (effValid) begin
        strb.take = 1'b1;
        strb.fire = 1'b1;
        stateNext = ST_DONE;
      end
      ST_DONE: stateNext = ST_DONE;
      default: stateNext = ST_DONE;
    endcase
  end

  assign trackDone = (state == ST_DONE);

  AST_BAD_INIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_INIT && effValid && effData != INIT_CHAR) |=> trackDone); // R2
  AST_DONE_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    trackDone |=> trackDone); // R11
  AST_RESP_IND: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RS_P0 && effValid && !effData[NIB_W]) |=> trackDone); // R9
  AST_RESP_TAG: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RS_P1 && effValid && effData[BYTE_W-1:MULT_W] != MULT_TAG)
      |=> trackDone); // R10

endmodule

// File: rtl/card_speed_tracker.sv
module card_speed_tracker
  import card_speed_pkg::*;
#(
  parameter logic [BYTE_W-1:0] INIT_CHAR = 8'h3B,
  parameter logic [BYTE_W-1:0] PPS_START = 8'hFF,
  parameter logic [TAG_W-1:0]  MULT_TAG  = 6'b100101
) (
  input  logic              clk,
  input  logic              cardRstN,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  output logic              speedTrigger,
  output logic [MULT_W-1:0] speedMult,
  output logic              trackDone
);

  ctlStrobe_t        strb;
  logic              effValid;
  logic [BYTE_W-1:0] effData;
  logic [NIB_W-1:0]  presY;
  logic [NIB_W-1:0]  histCnt;
  logic              chkFlag;
  logic [SEL_W-1:0]  ppsSel;

  card_speed_ctrl #(
    .INIT_CHAR(INIT_CHAR),
    .PPS_START(PPS_START),
    .MULT_TAG (MULT_TAG)
  ) uCtrl (
    .clk      (clk),
    .rstN     (cardRstN),
    .effValid (effValid),
    .effData  (effData),
    .presY    (presY),
    .histCnt  (histCnt),
    .chkFlag  (chkFlag),
    .ppsSel   (ppsSel),
    .strb     (strb),
    .trackDone(trackDone)
  );

  card_speed_dpath uDpath (
    .clk         (clk),
    .rstN        (cardRstN),
    .byteValid   (byteValid),
    .byteData    (byteData),
    .strb        (strb),
    .effValid    (effValid),
    .effData     (effData),
    .presY       (presY),
    .histCnt     (histCnt),
    .chkFlag     (chkFlag),
    .ppsSel      (ppsSel),
    .speedMult   (speedMult),
    .speedTrigger(speedTrigger)
  );

  AST_TRIG_IN_DONE: assert property (@(posedge clk) disable iff (!cardRstN)
    speedTrigger |-> trackDone); // R11
  AST_MULT_HOLD: assert property (@(posedge clk) disable iff (!cardRstN)
    trackDone |=> $stable(speedMult)); // R11

endmodule

// File: tb/tb_card_speed_tracker.sv
module tb_card_speed_tracker;

  logic       clk = 1'b0;
  logic       cardRstN;
  logic       byteValid;
  logic [7:0] byteData;
  logic       speedTrigger;
  logic [1:0] speedMult;
  logic       trackDone;

  always #5 clk = ~clk;

  card_speed_tracker dut (
    .clk         (clk),
    .cardRstN    (cardRstN),
    .byteValid   (byteValid),
    .byteData    (byteData),
    .speedTrigger(speedTrigger),
    .speedMult   (speedMult),
    .trackDone   (trackDone)
  );

  int checkCnt = 0;
  int failCnt  = 0;
  int cyc      = 0;

  logic [7:0] seqMem [0:63];
  int         seqGap [0:63];
  int         seqLen;

  int trigCnt, trigRun, trigMax;

  task automatic summary();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual %0d cycles expected below 190000", cyc);
      summary();
      $finish;
    end
  end

  always @(negedge clk) begin
    if (cardRstN === 1'b1) begin
      if (speedTrigger) begin
        trigCnt++;
        trigRun++;
        if (trigRun > trigMax) trigMax = trigRun;
      end else begin
        trigRun = 0;
      end
    end
  end

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    seqMem[seqLen] = b;
    seqGap[seqLen] = 8 + int'($urandom % 5);
    seqLen++;
  endtask

  function automatic bit getB(inout int p, output logic [7:0] b);
    if (p >= seqLen) return 1'b0;
    b = seqMem[p];
    p++;
    return 1'b1;
  endfunction

  // Expected outcome derived from the requirements
  function automatic void refModel(output bit eFire, output logic [1:0] eMult,
                                   output bit eDone);
    int p = 0;
    logic [7:0] b;
    logic [3:0] y, k;
    logic [2:0] pr;
    bit tck = 0;
    bit fin = 0;
    eFire = 0; eMult = 2'd0; eDone = 0;
    if (!getB(p, b)) return;
    if (b != 8'h3B) begin eDone = 1; return; end
    if (!getB(p, b)) return;
    y = b[7:4]; k = b[3:0];
    while (!fin) begin
      for (int j = 0; j < 3; j++) if (y[j]) begin if (!getB(p, b)) return; end
      if (y[3]) begin
        if (!getB(p, b)) return;
        y = b[7:4];
        if (b[3:0] != 4'd0) tck = 1;
      end else fin = 1;
    end
    for (int j = 0; j < int'(k); j++) if (!getB(p, b)) return;
    if (tck) if (!getB(p, b)) return;
    if (!getB(p, b)) return;
    if (b != 8'hFF) begin eDone = 1; return; end
    if (!getB(p, b)) return;
    pr = b[6:4];
    for (int j = 0; j < 3; j++) if (pr[j]) begin if (!getB(p, b)) return; end
    if (!getB(p, b)) return;
    if (!getB(p, b)) return;
    if (b != 8'hFF) begin eDone = 1; return; end
    if (!getB(p, b)) return;
    if (!b[4]) begin eDone = 1; return; end
    pr = b[6:4];
    if (!getB(p, b)) return;
    if (b[7:2] != 6'b100101) begin eDone = 1; return; end
    eMult = b[1:0];
    for (int j = 1; j < 3; j++) if (pr[j]) begin if (!getB(p, b)) return; end
    if (!getB(p, b)) return;
    eFire = 1; eDone = 1;
  endfunction

  task automatic doReset();
    @(negedge clk);
    cardRstN  = 1'b0;
    byteValid = 1'b1;
    byteData  = 8'h3B;
    repeat (3) @(negedge clk);
    check("R1 reset trigger", speedTrigger == 1'b0, int'(speedTrigger), 0);
    check("R1 reset mult", speedMult == 2'd0, int'(speedMult), 0);
    check("R1 reset done", trackDone == 1'b0, int'(trackDone), 0);
    byteValid = 1'b0;
    cardRstN  = 1'b1;
    trigCnt = 0; trigRun = 0; trigMax = 0;
    @(negedge clk);
  endtask

  task automatic sendAll(input int upTo);
    for (int i = 0; i < upTo; i++) begin
      byteValid = 1'b1;
      byteData  = seqMem[i];
      @(negedge clk);
      byteValid = 1'b0;
      repeat (seqGap[i]) @(negedge clk);
    end
    repeat (10) @(negedge clk);
  endtask

  task automatic runCase(input string tag);
    bit eFire, eDone;
    logic [1:0] eMult;
    doReset();
    sendAll(seqLen);
    refModel(eFire, eMult, eDone);
    check({tag, " done"}, trackDone == eDone, int'(trackDone), int'(eDone));
    check({tag, " mult"}, speedMult == eMult, int'(speedMult), int'(eMult));
    check({tag, " trigger count (R11)"}, trigCnt == int'(eFire), trigCnt, int'(eFire));
    if (eFire)
      check({tag, " trigger width R11"}, trigMax == 1, trigMax, 1);
  endtask

  // Good exchange: no interface bytes, request with PPS1, reply multiplier 2
  task automatic buildBasic(input logic [7:0] fmt);
    seqLen = 0;
    push(8'h3B); push(fmt);
    push(8'hFF); push(8'h10); push(8'h11); push(8'hEE);
    push(8'hFF); push(8'h10); push(8'h96); push(8'h5A);
    push(8'hFF); push(8'h3B);
  endtask

  task automatic genRandom();
    logic [3:0] y, nib;
    logic [3:0] k;
    logic [2:0] sel, rs;
    bit tck = 0, fin = 0, t;
    int lvl = 0;
    seqLen = 0;
    push(($urandom % 10 == 0) ? 8'h3F : 8'h3B);
    y = 4'($urandom % 16);
    k = 4'($urandom % 4);
    push({y, k});
    while (!fin) begin
      for (int j = 0; j < 3; j++) if (y[j]) push(8'($urandom));
      if (y[3]) begin
        nib = 4'($urandom % 16);
        if (lvl >= 2) nib[3] = 1'b0;
        t = 1'($urandom % 2);
        if (t) tck = 1;
        push({nib, 3'b000, t});
        y = nib;
        lvl++;
      end else fin = 1;
    end
    for (int j = 0; j < int'(k); j++) push(8'($urandom));
    if (tck) push(8'($urandom));
    push(($urandom % 10 == 0) ? 8'h7E : 8'hFF);
    sel = 3'($urandom % 8);
    push({1'b0, sel, 4'h1});
    for (int j = 0; j < 3; j++) if (sel[j]) push(8'($urandom));
    push(8'($urandom));
    push(($urandom % 10 == 0) ? 8'h00 : 8'hFF);
    rs = 3'($urandom % 8);
    if ($urandom % 10 != 0) rs[0] = 1'b1;
    push({1'b0, rs, 4'h1});
    push(($urandom % 7 == 0) ? 8'($urandom) : {6'b100101, 2'($urandom % 4)});
    for (int j = 1; j < 3; j++) if (rs[j]) push(8'($urandom));
    push(8'($urandom));
    push(8'($urandom));
    push(8'($urandom));
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    cardRstN  = 1'b0;
    byteValid = 1'b0;
    byteData  = 8'h00;
    trigCnt = 0; trigRun = 0; trigMax = 0;
    repeat (2) @(negedge clk);

    // R11 basic confirmed exchange, extra bytes after the end
    buildBasic(8'h00);
    runCase("R10 R11 basic exchange");
    check("R10 basic mult value", speedMult == 2'd2, int'(speedMult), 2);

    // R1 reset after completion clears outputs
    buildBasic(8'h00);
    runCase("R1 reset after done");

    // R2 wrong initial character
    buildBasic(8'h00);
    seqMem[0] = 8'h3F;
    runCase("R2 bad initial");
    check("R2 no trigger", trigCnt == 0, trigCnt, 0);

    // R12 byte lands during skip cycles right after the format byte
    buildBasic(8'h00);
    seqGap[1] = 0;
    runCase("R12 held byte");
    check("R12 trigger fired", trigCnt == 1, trigCnt, 1);

    // R3 R5 A and C bytes, three historical bytes
    seqLen = 0;
    push(8'h3B); push(8'h53); push(8'h11); push(8'h22);
    push(8'hA1); push(8'hA2); push(8'hA3);
    push(8'hFF); push(8'h00); push(8'h99);
    push(8'hFF); push(8'h70); push(8'h97); push(8'h01); push(8'h02); push(8'h03);
    runCase("R3 R5 R7 interface and history");
    check("R3 mult value", speedMult == 2'd3, int'(speedMult), 3);

    // R4 chained D bytes, nonzero low nibble demands a check byte
    seqLen = 0;
    push(8'h80); seqLen = 0;
    push(8'h3B); push(8'h80); push(8'h81); push(8'h01);
    push(8'hC3);
    push(8'hFF); push(8'h30); push(8'h44); push(8'h55); push(8'h66);
    push(8'hFF); push(8'h10); push(8'h94); push(8'h77);
    runCase("R4 R7 chained groups");
    check("R4 trigger fired", trigCnt == 1, trigCnt, 1);

    // R6 request not started by FF
    buildBasic(8'h00);
    seqMem[2] = 8'hFE;
    runCase("R6 no request");

    // R8 reply not started by FF
    buildBasic(8'h00);
    seqMem[6] = 8'h12;
    runCase("R8 no reply");

    // R9 reply indicator bit clear
    buildBasic(8'h00);
    seqMem[7] = 8'h60;
    runCase("R9 indicator clear");
    check("R9 no trigger", trigCnt == 0, trigCnt, 0);

    // R10 tag mismatch
    buildBasic(8'h00);
    seqMem[8] = 8'h86;
    runCase("R10 tag mismatch");
    check("R10 mult untouched", speedMult == 2'd0, int'(speedMult), 0);

    // R1 reset in the middle of an exchange, then a clean run
    buildBasic(8'h00);
    doReset();
    sendAll(8);
    buildBasic(8'h00);
    runCase("R1 restart after partial");

    for (int n = 0; n < 60; n++) begin
      genRandom();
      runCase("R3 R4 R5 R7 random");
    end

    summary();
    $finish;
  end

endmodule